// File: doc/BRIEF.md
# Damped Spring-Mass Oscillator Solver

This block is a small digital differential analyzer. It solves the motion of a damped spring-mass system in hardware. The second-order equation x'' = -k·x - d·x' is recast as two coupled first-order equations, one for position and one for velocity. A register holds each state, and both states advance together by a forward-Euler step. The time step is a power of two, so scaling a derivative by dt is an arithmetic right shift and needs no multiplier.

All states and coefficients are 18-bit signed fixed-point numbers with 16 fraction bits, covering -2.0 up to just under +2.0. Two fractional multipliers form the spring and damping terms, and their negated sum becomes the velocity derivative. A free-running divider sets the pace: the states move only on one clock in every 2^DIV_LOG. The upper 16 bits of the position form an audio sample. A select input puts either that sample or an external sample on the sample output.

Top module: `springSolver`

## Requirements
- R1: While `rst` is high at a rising clock edge, the position register loads `pos0`, the velocity register loads `vel0`, and the step divider clears.
- R2: The states change only on step cycles. With the divider cleared, the first step falls on the 2^DIV_LOG-th rising edge after `rst` goes low, and later steps follow every 2^DIV_LOG edges. No two steps are adjacent when DIV_LOG > 0.
- R3: On a step, position becomes pos + (vel >>> DT_SHIFT), using the velocity from before the step and wrapping modulo 2^18.
- R4: On a step, velocity becomes vel + (a >>> DT_SHIFT), where a = -(kCoef·pos) - (dCoef·vel). Both products use the pre-step states, and the sums wrap modulo 2^18. With both coefficients zero, velocity stays unchanged.
- R5: Each fractional product is the full 36-bit signed product, bits [33:16]. This is truncation toward minus infinity, and the value 1.0 is encoded as 18'h10000.
- R6: The shifts are arithmetic. A velocity of -1 LSB (18'h3FFFF) with DT_SHIFT=8 lowers the position by exactly 1 LSB per step, and a zero velocity leaves the position unchanged.
- R7: `sampleOut` equals `posOut[17:2]` when `selCompute` is 1 and `extSample` when it is 0. The path is combinational.
- R8: With positive spring and damping coefficients, the oscillation decays. With pos0 = 0.5, vel0 = 0, k = 1.0 and d = 0.25 (DT_SHIFT=8), the peak |position| over steps 2400 to 4000 is below 0.25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset that loads the initial conditions |
| pos0 | input | 18 | Initial position, signed 2.16 |
| vel0 | input | 18 | Initial velocity, signed 2.16 |
| kCoef | input | 18 | Spring coefficient k/m, signed 2.16 |
| dCoef | input | 18 | Damping coefficient d/m, signed 2.16 |
| extSample | input | 16 | External passthrough audio sample |
| selCompute | input | 1 | 1 selects the computed sample, 0 selects the passthrough sample |
| posOut | output | 18 | Position state |
| velOut | output | 18 | Velocity state |
| sampleOut | output | 16 | Selected audio sample |

## Verification
A wrong product slice, a logical instead of arithmetic shift, or a missing sign on the acceleration makes `velOut` differ from the bench's fixed-point model at the first step. `posOut` then diverges one step later. A divider fault moves state changes onto the wrong edge, which shows inside the first 2^DIV_LOG cycles after reset. The state must hold still between steps, so early or extra updates are caught at once. Errors that only build up slowly, such as a biased rounding in the damping term, show in the long decay run as a peak amplitude that does not shrink.

// File: rtl/springPkg.sv
package springPkg;
  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobe_t;
endpackage

// File: rtl/fracMul.sv
module fracMul #(
  parameter int W    = 18,
  parameter int FRAC = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam int PW = 2 * W;
  logic signed [PW-1:0] prod;
  assign prod = PW'(a) * PW'(b);
  assign y    = prod[FRAC+W-1:FRAC];
endmodule

// File: rtl/springCtrl.sv
module springCtrl
  import springPkg::*;
#(
  parameter int DIV_LOG = 4
) (
  input  logic        clk,
  input  logic        rst,
  output ctrlStrobe_t strobe
);
  logic stepRaw;

  generate
    if (DIV_LOG == 0) begin : gNoDiv
      assign stepRaw = !rst;
    end else begin : gDiv
      logic [DIV_LOG-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (rst) divCnt <= '0;
        else     divCnt <= divCnt + 1'b1;
      end
      assign stepRaw = !rst && (&divCnt);
    end
  endgenerate

  assign strobe.load = rst;
  assign strobe.step = stepRaw;
endmodule

// File: rtl/springPath.sv
module springPath
  import springPkg::*;
#(
  parameter int W        = 18,
  parameter int FRAC     = 16,
  parameter int DT_SHIFT = 8
) (
  input  logic               clk,
  input  ctrlStrobe_t        strobe,
  input  logic signed [W-1:0] pos0,
  input  logic signed [W-1:0] vel0,
  input  logic signed [W-1:0] kCoef,
  input  logic signed [W-1:0] dCoef,
  output logic signed [W-1:0] posQ,
  output logic signed [W-1:0] velQ
);
  logic signed [W-1:0] springTerm, dampTerm, accel, posNext, velNext;

  fracMul #(.W(W), .FRAC(FRAC)) i_springMul (.a(kCoef), .b(posQ), .y(springTerm));
  fracMul #(.W(W), .FRAC(FRAC)) i_dampMul   (.a(dCoef), .b(velQ), .y(dampTerm));

  assign accel   = -springTerm - dampTerm;
  assign posNext = posQ + (velQ >>> DT_SHIFT);
  assign velNext = velQ + (accel >>> DT_SHIFT);

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      posQ <= pos0;
      velQ <= vel0;
    end else if (strobe.step) begin
      posQ <= posNext;
      velQ <= velNext;
    end
  end
endmodule

// File: rtl/springSolver.sv
module springSolver
  import springPkg::*;
#(
  parameter int W        = 18,
  parameter int FRAC     = 16,
  parameter int DT_SHIFT = 8,
  parameter int DIV_LOG  = 4,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] pos0,
  input  logic signed [W-1:0] vel0,
  input  logic signed [W-1:0] kCoef,
  input  logic signed [W-1:0] dCoef,
  input  logic [SAMPLE_W-1:0] extSample,
  input  logic                selCompute,
  output logic signed [W-1:0] posOut,
  output logic signed [W-1:0] velOut,
  output logic [SAMPLE_W-1:0] sampleOut
);
  ctrlStrobe_t ctrlBus;

  springCtrl #(.DIV_LOG(DIV_LOG)) i_ctrl (
    .clk(clk), .rst(rst), .strobe(ctrlBus)
  );

  springPath #(.W(W), .FRAC(FRAC), .DT_SHIFT(DT_SHIFT)) i_path (
    .clk(clk), .strobe(ctrlBus), .pos0(pos0), .vel0(vel0),
    .kCoef(kCoef), .dCoef(dCoef), .posQ(posOut), .velQ(velOut)
  );

  assign sampleOut = selCompute ? posOut[W-1:W-SAMPLE_W] : extSample;
endmodule

// File: rtl/springSolverChk.sv
module springSolverChk #(
  parameter int W        = 18,
  parameter int DIV_LOG  = 4,
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                stepEn,
  input logic signed [W-1:0] pos0,
  input logic signed [W-1:0] vel0,
  input logic signed [W-1:0] kCoef,
  input logic signed [W-1:0] dCoef,
  input logic signed [W-1:0] posOut,
  input logic signed [W-1:0] velOut,
  input logic [SAMPLE_W-1:0] extSample,
  input logic                selCompute,
  input logic [SAMPLE_W-1:0] sampleOut
);
  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> (posOut == $past(pos0) && velOut == $past(vel0))); // R1

  AST_HOLD_OFF_STEP: assert property (@(posedge clk) disable iff (rst)
    !stepEn |=> ($stable(posOut) && $stable(velOut))); // R2

  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (rst)
    ((DIV_LOG > 0) && stepEn) |=> !stepEn); // R2

  AST_ZERO_VEL_HOLDS_POS: assert property (@(posedge clk) disable iff (rst)
    (stepEn && velOut == '0) |=> $stable(posOut)); // R6

  AST_NO_COEF_HOLDS_VEL: assert property (@(posedge clk) disable iff (rst)
    (stepEn && kCoef == '0 && dCoef == '0) |=> $stable(velOut)); // R4

  AST_SAMPLE_COMPUTED: assert property (@(posedge clk) disable iff (rst)
    selCompute |-> (sampleOut == posOut[W-1:W-SAMPLE_W])); // R7

  AST_SAMPLE_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    !selCompute |-> (sampleOut == extSample)); // R7
endmodule

bind springSolver springSolverChk #(.W(W), .DIV_LOG(DIV_LOG), .SAMPLE_W(SAMPLE_W)) i_chk (
  .clk(clk), .rst(rst), .stepEn(ctrlBus.step), .pos0(pos0), .vel0(vel0),
  .kCoef(kCoef), .dCoef(dCoef), .posOut(posOut), .velOut(velOut),
  .extSample(extSample), .selCompute(selCompute), .sampleOut(sampleOut)
);

// File: tb/test_springSolver.sv
module test_springSolver;
  localparam int W = 18;
  localparam int DT = 8;
  localparam int DIVL = 2;
  localparam int PER = 1 << DIVL;

  logic clk = 0;
  logic rst = 1;
  logic signed [W-1:0] pos0 = '0, vel0 = '0, kCoef = '0, dCoef = '0;
  logic [15:0] extSample = '0;
  logic selCompute = 1;
  logic signed [W-1:0] posOut, velOut;
  logic [15:0] sampleOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic signed [W-1:0] mPos, mVel;

  always #2 clk = ~clk;

  springSolver #(.W(W), .FRAC(16), .DT_SHIFT(DT), .DIV_LOG(DIVL), .SAMPLE_W(16)) i_springSolver (
    .clk(clk), .rst(rst), .pos0(pos0), .vel0(vel0), .kCoef(kCoef), .dCoef(dCoef),
    .extSample(extSample), .selCompute(selCompute),
    .posOut(posOut), .velOut(velOut), .sampleOut(sampleOut)
  );

  function automatic logic signed [W-1:0] qmul(logic signed [W-1:0] a, logic signed [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = 36'(a) * 36'(b);
    return p[33:16];
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic modelStep();
    logic signed [W-1:0] acc, nPos, nVel;
    acc  = -qmul(kCoef, mPos) - qmul(dCoef, mVel);
    nPos = mPos + (mVel >>> DT);
    nVel = mVel + (acc >>> DT);
    mPos = nPos;
    mVel = nVel;
  endtask

  task automatic doReset(logic signed [W-1:0] p, logic signed [W-1:0] v);
    @(negedge clk);
    pos0 = p; vel0 = v; rst = 1;
    @(posedge clk); @(negedge clk);
    check("R1 pos load", posOut, p);
    check("R1 vel load", velOut, v);
    rst = 0;
    mPos = p; mVel = v;
  endtask

  // one Euler step: states must hold for PER-1 edges, then match the model
  task automatic runStep(bit strict, bit sampleChk);
    for (int i = 0; i < PER; i++) begin
      @(posedge clk); @(negedge clk);
      if (i < PER - 1) begin
        if (strict) begin
          check("R2 hold pos", posOut, mPos);
          check("R2 hold vel", velOut, mVel);
        end
      end else begin
        modelStep();
        check("R3 pos step", posOut, mPos);
        check("R4 R5 vel step", velOut, mVel);
      end
      if (sampleChk) begin
        selCompute = 1'($urandom);
        extSample  = 16'($urandom);
        #0;
        check("R7 sample", 18'(sampleOut), selCompute ? 18'(posOut[17:2]) : 18'(extSample));
      end
    end
  endtask

  initial begin
    logic signed [W-1:0] peak, absPos;
    void'($urandom(32'd5150));
    // reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset pos", posOut, 18'h0);
    check("R1 reset vel", velOut, 18'h0);
    check("R7 reset sample", 18'(sampleOut), 18'h0);

    // directed extremes then random coefficient sets
    for (int s = 0; s < 6; s++) begin
      case (s)
        0: begin kCoef = 18'sh20000; dCoef = 18'sh1FFFF; end   // -2.0 and max
        1: begin kCoef = 18'sh0; dCoef = 18'sh0; end           // R4 no coefficients
        2: begin kCoef = 18'sh10000; dCoef = 18'sh3F000; end   // 1.0 and negative damping
        default: begin kCoef = 18'($urandom); dCoef = 18'($urandom); end
      endcase
      doReset(18'($urandom), 18'($urandom));
      for (int n = 0; n < 40; n++) runStep(1, 1);
    end

    // R6: velocity of -1 LSB lowers position by 1 LSB each step
    selCompute = 1;
    kCoef = '0; dCoef = '0;
    doReset(18'sh00100, 18'sh3FFFF);
    runStep(1, 0);
    check("R6 neg vel step1", posOut, 18'h000FF);
    runStep(1, 0);
    check("R6 neg vel step2", posOut, 18'h000FE);
    check("R6 vel kept", velOut, 18'h3FFFF);
    // R6: zero velocity leaves position alone
    doReset(18'sh12345, 18'sh0);
    runStep(1, 0);
    check("R6 zero vel", posOut, 18'h12345);

    // R7 directed passthrough
    @(negedge clk);
    selCompute = 0; extSample = 16'hA5C3; #1;
    check("R7 passthru", 18'(sampleOut), 18'h0A5C3);
    selCompute = 1; #1;
    check("R7 computed", 18'(sampleOut), 18'(posOut[17:2]));

    // R8: damped decay, model checked every step
    kCoef = 18'sh10000; dCoef = 18'sh04000;
    doReset(18'sh08000, 18'sh0);
    peak = '0;
    for (int n = 0; n < 4000; n++) begin
      runStep(0, 0);
      if (n >= 2400) begin
        absPos = posOut[W-1] ? -posOut : posOut;
        if (absPos > peak) peak = absPos;
      end
    end
    total++;
    if (!(peak < 18'sh04000)) begin
      bad++;
      $display("FAIL R8 decay peak act=%h exp<%h", peak, 18'h04000);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule